// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell Bank

This block sits between a group of bidirectional pins and the internal routing network. Each cell in the group carries one internal signal out to its pin and one pin value back in. A small per-cell configuration field picks how the cell behaves:

- a plain combinational input;
- an input sampled by a flip-flop on the I/O clock;
- an input held in a level-sensitive latch;
- a driver that is always on;
- a three-state bidirectional pin.

A per-cell polarity bit can invert the driven value.

All cells in the bank share one output-enable input. In bidirectional mode that signal gates the driver. A driver in output-only mode is on no matter what the shared enable says, and a driver in an input mode is always off. An active-low global reset clears the input flip-flop and the input latch of every cell. The pin itself is modelled as a tri-state triple: driven value, driver enable and sensed value. Electrical levels are not modelled.

Top module: `pad_bank`

## Requirements
- R1: With mode code 0 (combinational input), core_din of that cell equals its pad_in at once, and pad_oe is 0.
- R2: With mode code 1 (registered input), core_din takes the pad_in value present at a rising io_clk edge and keeps it until the next rising edge.
- R3: With mode code 2 (latched input), core_din follows pad_in while io_clk is high. It keeps the last value while io_clk is low.
- R4: With mode code 3 (output only), pad_oe is 1 regardless of grp_oe, and core_din is 0 whatever the pin carries.
- R5: With mode code 4 (bidirectional), pad_oe equals grp_oe, and core_din equals pad_in at once.
- R6: pad_out of a cell equals its core_dout when its cfg_inv bit is 0. It equals the complement when cfg_inv is 1. This holds in every mode.
- R7: While glob_rst_n is 0, the input latch clears at once and the input flip-flop clears at the next rising io_clk edge. Cells in mode 1 or 2 then return 0.
- R8: Mode codes 5, 6 and 7 behave exactly like mode code 0.
- R9: The single grp_oe input drives every bidirectional cell of the bank together. Each cell's mode field is at bits [3*i+2:3*i] of cfg_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_clk | input | 1 | I/O clock for the input flip-flop; it is also the latch enable |
| glob_rst_n | input | 1 | Global reset, active low |
| grp_oe | input | 1 | Output enable shared by the whole bank |
| cfg_mode | input | 3*NCELL | Per-cell 3-bit mode code |
| cfg_inv | input | NCELL | Per-cell output inversion |
| core_dout | input | NCELL | Data from internal logic, one bit per cell |
| pad_in | input | NCELL | Value sensed on each pin |
| pad_out | output | NCELL | Value driven toward each pin |
| pad_oe | output | NCELL | Driver enable for each pin |
| core_din | output | NCELL | Pin value returned to the routing network |

## Verification
The hardest case to reach is the latch hold window. The pin has to change while io_clk is low, and the bench has to see that core_din does not move until the clock rises again. The bench does this by changing pad_in one nanosecond after the falling edge and sampling before the next rising edge. It then samples again just after the rise to see the latch become transparent. The reset case is reached in a similar way. The pin is held at 1 while reset is applied, so the cleared latch and flip-flop can be told apart from the pin value.

// File: rtl/padcell_pkg.sv
package padcell_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [2:0] {
    PM_COMB  = 3'd0,
    PM_REG   = 3'd1,
    PM_LATCH = 3'd2,
    PM_OUT   = 3'd3,
    PM_BIDIR = 3'd4
  } pad_mode_e;

  typedef enum logic [1:0] {
    SRC_PIN   = 2'd0,
    SRC_FLOP  = 2'd1,
    SRC_LATCH = 2'd2,
    SRC_ZERO  = 2'd3
  } ret_src_e;

  // Unlisted codes fall back to combinational input.
  function automatic pad_mode_e decode_mode(input logic [MODE_W-1:0] raw);
    case (raw)
      3'd1:    return PM_REG;
      3'd2:    return PM_LATCH;
      3'd3:    return PM_OUT;
      3'd4:    return PM_BIDIR;
      default: return PM_COMB;
    endcase
  endfunction

endpackage

// File: rtl/pad_mode_decode.sv
module pad_mode_decode
  import padcell_pkg::*;
(
  input  logic [MODE_W-1:0] raw_mode,
  output pad_mode_e         mode,
  output logic              oe_always,
  output logic              oe_shared,
  output ret_src_e          ret_src
);

  always_comb begin
    mode      = decode_mode(raw_mode);
    oe_always = 1'b0;
    oe_shared = 1'b0;
    ret_src   = SRC_PIN;
    case (mode)
      PM_REG:   ret_src = SRC_FLOP;
      PM_LATCH: ret_src = SRC_LATCH;
      PM_OUT: begin
        oe_always = 1'b1;
        ret_src   = SRC_ZERO;
      end
      PM_BIDIR: oe_shared = 1'b1;
      default:  ret_src = SRC_PIN;
    endcase
  end

endmodule

// File: rtl/pad_capture.sv
module pad_capture (
  input  logic io_clk,
  input  logic rst_n,
  input  logic pin,
  output logic flop_q,
  output logic latch_q
);

  always_ff @(posedge io_clk) begin
    if (!rst_n) flop_q <= 1'b0;
    else        flop_q <= pin;
  end

  // Transparent while io_clk is high, holds while low, cleared by reset.
  always_latch begin
    if (!rst_n)      latch_q = 1'b0;
    else if (io_clk) latch_q = pin;
  end

endmodule

// File: rtl/pad_cell.sv
module pad_cell
  import padcell_pkg::*;
(
  input  logic              io_clk,
  input  logic              rst_n,
  input  logic              grp_oe,
  input  logic [MODE_W-1:0] raw_mode,
  input  logic              inv,
  input  logic              dout,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              din
);

  pad_mode_e mode;
  logic      oe_always, oe_shared;
  ret_src_e  ret_src;
  logic      flop_q, latch_q;

  pad_mode_decode u_dec (
    .raw_mode (raw_mode),
    .mode     (mode),
    .oe_always(oe_always),
    .oe_shared(oe_shared),
    .ret_src  (ret_src)
  );

  pad_capture u_cap (
    .io_clk (io_clk),
    .rst_n  (rst_n),
    .pin    (pin_in),
    .flop_q (flop_q),
    .latch_q(latch_q)
  );

  assign pin_out = inv ? ~dout : dout;
  assign pin_oe  = oe_always | (oe_shared & grp_oe);

  always_comb begin
    case (ret_src)
      SRC_FLOP:  din = flop_q;
      SRC_LATCH: din = latch_q;
      SRC_ZERO:  din = 1'b0;
      default:   din = pin_in;
    endcase
  end

  // R1, R8: every input mode leaves the driver off
  a_r1_input_no_drive: assert property (@(posedge io_clk) disable iff (!rst_n)
    (mode == PM_COMB || mode == PM_REG || mode == PM_LATCH) |-> !pin_oe);

  // R2: the returned value is the pin value from the previous edge
  a_r2_flop_delay: assert property (@(posedge io_clk) disable iff (!rst_n)
    ($past(rst_n) && mode == PM_REG && $past(mode) == PM_REG) |-> din == $past(pin_in));

  // R4: output-only cell drives and returns zero
  a_r4_out_drive: assert property (@(posedge io_clk) disable iff (!rst_n)
    (mode == PM_OUT) |-> (pin_oe && !din));

  // R5: bidirectional cell follows the shared enable
  a_r5_bidir_oe: assert property (@(posedge io_clk) disable iff (!rst_n)
    (mode == PM_BIDIR) |-> (pin_oe == grp_oe && din == pin_in));

  // R6: no inversion passes data straight through
  a_r6_polarity: assert property (@(posedge io_clk) disable iff (!rst_n)
    (!inv) |-> (pin_out == dout));

  // R7: first edge after reset returns the cleared flip-flop
  a_r7_reset_clear: assert property (@(posedge io_clk) disable iff (!rst_n)
    (!$past(rst_n) && mode == PM_REG) |-> !din);

endmodule

// File: rtl/pad_bank.sv
module pad_bank
  import padcell_pkg::*;
#(
  parameter int NCELL = 16
) (
  input  logic                    io_clk,
  input  logic                    glob_rst_n,
  input  logic                    grp_oe,
  input  logic [NCELL*MODE_W-1:0] cfg_mode,
  input  logic [NCELL-1:0]        cfg_inv,
  input  logic [NCELL-1:0]        core_dout,
  input  logic [NCELL-1:0]        pad_in,
  output logic [NCELL-1:0]        pad_out,
  output logic [NCELL-1:0]        pad_oe,
  output logic [NCELL-1:0]        core_din
);

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    pad_cell u_cell (
      .io_clk  (io_clk),
      .rst_n   (glob_rst_n),
      .grp_oe  (grp_oe),
      .raw_mode(cfg_mode[i*MODE_W +: MODE_W]),
      .inv     (cfg_inv[i]),
      .dout    (core_dout[i]),
      .pin_in  (pad_in[i]),
      .pin_out (pad_out[i]),
      .pin_oe  (pad_oe[i]),
      .din     (core_din[i])
    );
  end

endmodule

// File: tb/sim_pad_bank.sv
`timescale 1ns/1ps
module sim_pad_bank;
  localparam int NC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          grp_oe = 1'b0;
  logic [NC*3-1:0] mode_v = '0;
  logic [NC-1:0] inv_v = '0, dout_v = '0, pin_v = '0;
  logic [NC-1:0] pout, poe, din;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pad_bank #(.NCELL(NC)) u0 (
    .io_clk(clk), .glob_rst_n(rst_n), .grp_oe(grp_oe), .cfg_mode(mode_v),
    .cfg_inv(inv_v), .core_dout(dout_v), .pad_in(pin_v),
    .pad_out(pout), .pad_oe(poe), .core_din(din));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic all_modes(input logic [2:0] m);
    for (int i = 0; i < NC; i++) mode_v[i*3 +: 3] = m;
  endtask

  task automatic t_reset_state;
    all_modes(3'd1);
    pin_v = '1;
    @(posedge clk); #1;
    chk("R7 flop cleared in reset", din, 16'h0000);
    all_modes(3'd2);
    #1 chk("R7 latch cleared in reset", din, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_comb;
    all_modes(3'd0);
    pin_v = 16'h1234; #1;
    chk("R1 comb follows pin", din, 16'h1234);
    chk("R1 comb no drive", poe, 16'h0000);
    pin_v = 16'hBEEF; #1;
    chk("R1 comb follows change", din, 16'hBEEF);
  endtask

  task automatic t_reg;
    all_modes(3'd1);
    @(negedge clk); pin_v = 16'h0F0F; @(posedge clk); #1;
    chk("R2 flop captured", din, 16'h0F0F);
    @(negedge clk); #1 pin_v = 16'hF0F0; #1;
    chk("R2 flop holds between edges", din, 16'h0F0F);
    @(posedge clk); #1;
    chk("R2 flop next edge", din, 16'hF0F0);
    chk("R1 reg mode no drive", poe, 16'h0000);
  endtask

  task automatic t_latch;
    all_modes(3'd2);
    @(posedge clk); #1 pin_v = 16'hAAAA; #1;
    chk("R3 latch transparent high", din, 16'hAAAA);
    @(negedge clk); #1 pin_v = 16'h5555; #1;
    chk("R3 latch holds low", din, 16'hAAAA);
    @(posedge clk); #1;
    chk("R3 latch reopens", din, 16'h5555);
  endtask

  task automatic t_out;
    all_modes(3'd3);
    pin_v = '1; grp_oe = 1'b0; #1;
    chk("R4 out drives with grp_oe 0", poe, 16'hFFFF);
    chk("R4 out returns zero", din, 16'h0000);
    grp_oe = 1'b1; #1;
    chk("R4 out drives with grp_oe 1", poe, 16'hFFFF);
  endtask

  task automatic t_bidir;
    all_modes(3'd4);
    pin_v = 16'h3C3C; grp_oe = 1'b0; #1;
    chk("R5 bidir oe off", poe, 16'h0000);
    chk("R5 bidir returns pin", din, 16'h3C3C);
    grp_oe = 1'b1; #1;
    chk("R5 bidir oe on", poe, 16'hFFFF);
  endtask

  task automatic t_polarity;
    dout_v = 16'hA5C3; inv_v = 16'h0000;
    for (int m = 0; m < 5; m++) begin
      all_modes(m[2:0]); #1;
      chk("R6 no inversion", pout, 16'hA5C3);
    end
    inv_v = 16'h00FF; #1;
    chk("R6 low byte inverted", pout, 16'hA53C);
    inv_v = 16'hFFFF; all_modes(3'd4); #1;
    chk("R6 full inversion bidir", pout, 16'h5A3C);
    inv_v = '0;
  endtask

  task automatic t_unused_codes;
    for (int c = 5; c < 8; c++) begin
      all_modes(c[2:0]); grp_oe = 1'b1;
      pin_v = 16'h6B1D; #1;
      chk("R8 unused code follows pin", din, 16'h6B1D);
      chk("R8 unused code no drive", poe, 16'h0000);
      pin_v = 16'h94E2; #1;
      chk("R8 unused code second value", din, 16'h94E2);
    end
  endtask

  task automatic t_shared_oe;
    all_modes(3'd0);
    mode_v[0*3 +: 3] = 3'd4;
    mode_v[5*3 +: 3] = 3'd4;
    mode_v[9*3 +: 3] = 3'd3;
    mode_v[15*3 +: 3] = 3'd4;
    grp_oe = 1'b0; #1;
    chk("R9 shared oe low", poe, 16'h0200);
    grp_oe = 1'b1; #1;
    chk("R9 shared oe high", poe, 16'h8221);
  endtask

  task automatic t_reset_again;
    all_modes(3'd0);
    mode_v[0 +: 3] = 3'd1;
    mode_v[3 +: 3] = 3'd2;
    pin_v = '1;
    @(posedge clk); #1;
    chk("R7 before reset", din & 16'h0003, 16'h0003);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R7 latch clears at once", din & 16'h0003, 16'h0001);
    @(posedge clk); #1;
    chk("R7 flop clears on edge", din & 16'h0003, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R7 recovers after reset", din & 16'h0003, 16'h0003);
  endtask

  initial begin
    t_reset_state();
    t_comb();
    t_reg();
    t_latch();
    t_out();
    t_bidir();
    t_polarity();
    t_unused_codes();
    t_shared_oe();
    t_reset_again();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule